// File: doc/BRIEF.md
# UART receive FIFO with trigger

This block is the receive-side queue of a UART. The deserializer pushes 12-bit entries into it. Each entry holds a character in bits 7:0 and error flags in bits 11:8. A bus read of the data register pops the oldest entry. At the same moment the error nibble of that entry is copied into a status byte. The block drives full and empty flags, a can-accept signal for the deserializer, and a receive interrupt level. The interrupt trigger level is fixed at one entry.

A mode input chooses the capacity. When it is high the queue holds 16 entries. When it is low the queue collapses to one holding slot. Any change of the mode input flushes the queue. A break event seen while the queue is in single-slot mode stores a break entry and sets a break flag in the status byte.

Occupancy is kept by a three-state machine: OCC_EMPTY, OCC_PARTIAL and OCC_FULL. Its transitions are:
- fill: from EMPTY to PARTIAL, when a push leaves the count below capacity.
- top-up: from EMPTY or PARTIAL to FULL, when a push brings the count to capacity.
- drain: from PARTIAL or FULL to EMPTY, when a pop leaves the count at zero.
- release: from FULL to PARTIAL, when a pop leaves the count between zero and capacity.
- hold: the state is kept when the count does not change class.
- flush: from any state to EMPTY, when the mode input changes.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, rx_empty=1, rx_full=0, can_accept=1, rx_irq=0, status_byte=0 and pop_data=0, and the queue is in single-slot mode.
- R2: In queue mode, entries leave in the order they were pushed. pop_data always shows the entry at the read position before the pop edge, and each pop of a non-empty queue advances the read position.
- R3: In queue mode, rx_full rises when the count reaches 16, and can_accept is low exactly when the count equals capacity. A push into a full queue (without a pop) is dropped, and the stored entries stay unchanged.
- R4: In single-slot mode, one push makes rx_full=1. A second push is dropped, and the next pop returns the first entry.
- R5: A pop of an empty queue returns the entry at the read position. The count and read position do not change, rx_empty stays 1 and rx_full is 0.
- R6: rx_irq is set when a push makes the count equal to 1. It is cleared when a pop leaves the count at 0, which includes a pop of an empty queue. Otherwise it holds its value. Set wins over clear.
- R7: In a cycle where fifo_en differs from the current mode, the mode takes the new value and the count and read position become zero, giving rx_empty=1 and rx_full=0 on the next cycle. Pushes, pops and breaks in that cycle are ignored. rx_irq keeps its value, and status_clr still applies.
- R8: On a pop, status_byte[3:0] takes bits 11:8 of the popped entry and status_byte[7:4] stays 0. status_clr clears the status byte. A pop in the same cycle wins over the clear.
- R9: In single-slot mode, brk_evt pushes the entry 0x400 (bit 10 set) in place of push_data and sets status_byte bit 2. In queue mode, brk_evt has no effect.
- R10: When a pop and a push occur in the same cycle, the pop is applied first. A full queue therefore accepts the push and stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 = 16-entry queue mode, 0 = single-slot mode |
| push_valid | input | 1 | Push request from the deserializer |
| push_data | input | 12 | Entry to push: character in bits 7:0, error flags in bits 11:8 |
| pop | input | 1 | Data register read strobe |
| status_clr | input | 1 | Write strobe of the status byte; clears it |
| brk_evt | input | 1 | Break condition seen on the line |
| pop_data | output | 12 | Entry at the read position |
| status_byte | output | 8 | Error nibble of the last popped entry |
| rx_full | output | 1 | Count equals capacity |
| rx_empty | output | 1 | Count is zero |
| can_accept | output | 1 | Count is below capacity |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
Directed sequences cover the cases a queue can get wrong:
- a full 16-entry fill followed by an overflow push, which separates dropping the push from overwriting the oldest slot;
- a complete drain, which tells correct ordering from wrong pointer wrap;
- pops on an empty queue, which isolate the interrupt clear from count movement;
- single-slot pushes and breaks, which show the mask collapsing to one slot;
- mode toggles while the queue holds data, which tell a flush from a plain mode switch.

A long random run then mixes pushes, pops, status clears, breaks and rare mode changes. These collide at full and empty, so it exercises the rule that a same-cycle pop is applied before the push.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_e;

    // Receive interrupt trigger level (fixed)
    localparam int unsigned TRIG_LEVEL = 1;
    // Bit set in a stored break entry
    localparam int unsigned BRK_BIT    = 10;
    // Lowest entry bit that belongs to the error nibble
    localparam int unsigned STAT_LSB   = 8;

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int unsigned ENTRY_W = 12,
    parameter int unsigned DEPTH   = 16,
    localparam int unsigned PTR_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PTR_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [PTR_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rd_data
);

    logic [ENTRY_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_idx == PTR_W'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import uart_rxq_pkg::*;
#(
    parameter int unsigned ENTRY_W = 12,
    parameter int unsigned DEPTH   = 16,
    localparam int unsigned PTR_W  = $clog2(DEPTH),
    localparam int unsigned CNT_W  = PTR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_en,
    input  logic               push_valid,
    input  logic [ENTRY_W-1:0] push_data,
    input  logic               pop,
    input  logic               brk_evt,
    output logic               wr_en,
    output logic [PTR_W-1:0]   wr_idx,
    output logic [ENTRY_W-1:0] wr_data,
    output logic [PTR_W-1:0]   rd_idx,
    output logic               pop_any,
    output logic               brk_req,
    output logic               irq_set,
    output logic               irq_clr,
    output logic               full,
    output logic               empty,
    output logic               can_accept
);

    localparam logic [ENTRY_W-1:0] BRK_ENTRY = ENTRY_W'(1) << BRK_BIT;

    occ_e             occ_q, occ_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_mid, lim;
    logic [PTR_W-1:0] rd_q, rd_d, rd_mid, mask;
    logic             mode_q, mode_chg, pop_take, push_req;

    // Pop is applied before push within a cycle
    always_comb begin
        mode_chg = (fifo_en != mode_q);
        lim      = mode_q ? CNT_W'(DEPTH) : CNT_W'(1);
        mask     = mode_q ? PTR_W'(DEPTH - 1) : '0;
        pop_take = !mode_chg && pop && (cnt_q != '0);
        pop_any  = !mode_chg && pop;
        cnt_mid  = cnt_q - CNT_W'(pop_take);
        rd_mid   = pop_take ? ((rd_q + PTR_W'(1)) & mask) : rd_q;
        brk_req  = !mode_chg && brk_evt && !mode_q;
        push_req = !mode_chg && (brk_req || push_valid);
        wr_en    = push_req && (cnt_mid < lim);
        wr_data  = brk_req ? BRK_ENTRY : push_data;
        wr_idx   = (rd_mid + cnt_mid[PTR_W-1:0]) & mask;
        irq_clr  = pop_any && (cnt_mid == CNT_W'(TRIG_LEVEL - 1));
        if (mode_chg) begin
            cnt_d = '0;
            rd_d  = '0;
        end else begin
            cnt_d = cnt_mid + CNT_W'(wr_en);
            rd_d  = rd_mid;
        end
        irq_set  = wr_en && (cnt_d == CNT_W'(TRIG_LEVEL));
    end

    // Occupancy state transitions
    always_comb begin
        occ_d = occ_q;
        unique case (occ_q)
            OCC_EMPTY: begin
                if (mode_chg)                occ_d = OCC_EMPTY;   // flush
                else if (cnt_d == lim)       occ_d = OCC_FULL;    // top-up
                else if (cnt_d != '0)        occ_d = OCC_PARTIAL; // fill
            end
            OCC_PARTIAL: begin
                if (mode_chg)                occ_d = OCC_EMPTY;   // flush
                else if (cnt_d == '0)        occ_d = OCC_EMPTY;   // drain
                else if (cnt_d == lim)       occ_d = OCC_FULL;    // top-up
            end
            OCC_FULL: begin
                if (mode_chg)                occ_d = OCC_EMPTY;   // flush
                else if (cnt_d == '0)        occ_d = OCC_EMPTY;   // drain
                else if (cnt_d != lim)       occ_d = OCC_PARTIAL; // release
            end
            default:                         occ_d = OCC_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q  <= OCC_EMPTY;
            cnt_q  <= '0;
            rd_q   <= '0;
            mode_q <= 1'b0;
        end else begin
            occ_q  <= occ_d;
            cnt_q  <= cnt_d;
            rd_q   <= rd_d;
            mode_q <= fifo_en;
        end
    end

    // Outputs from state
    always_comb begin
        full       = (occ_q == OCC_FULL);
        empty      = (occ_q == OCC_EMPTY);
        can_accept = (occ_q != OCC_FULL);
        rd_idx     = rd_q;
    end

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim); // R3
    AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> (cnt_q <= CNT_W'(1))); // R4
    AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == OCC_FULL && push_valid && !pop && !mode_chg) |=> (occ_q == OCC_FULL)); // R3
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (empty && cnt_q == '0 && rd_q == '0)); // R7

endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import uart_rxq_pkg::*;
#(
    parameter int unsigned STAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop_any,
    input  logic [STAT_W-1:0] popped_hi,
    input  logic              status_clr,
    input  logic              brk_req,
    input  logic              irq_set,
    input  logic              irq_clr,
    output logic [7:0]        status_byte,
    output logic              rx_irq
);

    localparam int unsigned BRK_POS = BRK_BIT - STAT_LSB;

    logic [STAT_W-1:0] stat_q, stat_d;
    logic              irq_q, irq_d;

    always_comb begin
        stat_d = stat_q;
        if (status_clr) stat_d = '0;
        if (pop_any)    stat_d = popped_hi;
        if (brk_req)    stat_d[BRK_POS] = 1'b1;
        irq_d = irq_q;
        if (irq_clr)    irq_d = 1'b0;
        if (irq_set)    irq_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            irq_q  <= irq_d;
        end
    end

    assign status_byte = 8'(stat_q);
    assign rx_irq      = irq_q;

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> rx_irq); // R6
    AST_STATUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr && !pop_any && !brk_req) |=> (status_byte == 8'h00)); // R8
    AST_BRK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> status_byte[BRK_POS]); // R9

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rxq_pkg::*;
#(
    parameter int unsigned ENTRY_W = 12,
    parameter int unsigned DEPTH   = 16,
    localparam int unsigned PTR_W  = $clog2(DEPTH),
    localparam int unsigned STAT_W = ENTRY_W - STAT_LSB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_en,
    input  logic               push_valid,
    input  logic [ENTRY_W-1:0] push_data,
    input  logic               pop,
    input  logic               status_clr,
    input  logic               brk_evt,
    output logic [ENTRY_W-1:0] pop_data,
    output logic [7:0]         status_byte,
    output logic               rx_full,
    output logic               rx_empty,
    output logic               can_accept,
    output logic               rx_irq
);

    logic               wr_en, pop_any, brk_req, irq_set, irq_clr;
    logic [PTR_W-1:0]   wr_idx, rd_idx;
    logic [ENTRY_W-1:0] wr_data, rd_data;

    rxq_ctrl #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .push_valid (push_valid),
        .push_data  (push_data),
        .pop        (pop),
        .brk_evt    (brk_evt),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rd_idx     (rd_idx),
        .pop_any    (pop_any),
        .brk_req    (brk_req),
        .irq_set    (irq_set),
        .irq_clr    (irq_clr),
        .full       (rx_full),
        .empty      (rx_empty),
        .can_accept (can_accept)
    );

    rxq_store #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    rxq_status #(.STAT_W(STAT_W)) status_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pop_any     (pop_any),
        .popped_hi   (rd_data[ENTRY_W-1:STAT_LSB]),
        .status_clr  (status_clr),
        .brk_req     (brk_req),
        .irq_set     (irq_set),
        .irq_clr     (irq_clr),
        .status_byte (status_byte),
        .rx_irq      (rx_irq)
    );

    assign pop_data = rd_data;

endmodule

// File: tb/uart_rx_fifo_tb.sv
module uart_rx_fifo_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0, push_valid = 1'b0, pop = 1'b0;
    logic        status_clr = 1'b0, brk_evt = 1'b0;
    logic [11:0] push_data = '0;
    logic [11:0] pop_data;
    logic [7:0]  status_byte;
    logic        rx_full, rx_empty, can_accept, rx_irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Bench model
    logic [11:0] m_mem [16];
    int          m_cnt = 0, m_rd = 0;
    bit          m_mode = 1'b0, m_irq = 1'b0;
    logic [3:0]  m_stat = '0;

    always #4 clk = ~clk;

    uart_rx_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push_valid(push_valid),
        .push_data(push_data), .pop(pop), .status_clr(status_clr), .brk_evt(brk_evt),
        .pop_data(pop_data), .status_byte(status_byte), .rx_full(rx_full),
        .rx_empty(rx_empty), .can_accept(can_accept), .rx_irq(rx_irq)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int lim_of(input bit mode);
        return mode ? 16 : 1;
    endfunction

    // One cycle: drive at negedge, check pop_data before the edge, outputs after it
    task automatic step(input bit pu, input logic [11:0] d, input bit po, input bit fe,
                        input bit bk, input bit sc, input string tag);
        bit chg, brk;
        int mask;
        push_valid = pu; push_data = d; pop = po; fifo_en = fe; brk_evt = bk; status_clr = sc;
        #1;
        chg = (fe != m_mode);
        if (po && !chg) chk(tag, "pop_data", 32'(pop_data), 32'(m_mem[m_rd]));
        if (sc) m_stat = '0;
        if (chg) begin
            m_mode = fe; m_cnt = 0; m_rd = 0;
        end else begin
            mask = lim_of(m_mode) - 1;
            if (po) begin
                m_stat = m_mem[m_rd][11:8];
                if (m_cnt > 0) begin m_cnt--; m_rd = (m_rd + 1) & mask; end
                if (m_cnt == 0) m_irq = 1'b0;
            end
            brk = bk && !m_mode;
            if (brk) m_stat[2] = 1'b1;
            if ((brk || pu) && m_cnt < lim_of(m_mode)) begin
                m_mem[(m_rd + m_cnt) & mask] = brk ? 12'h400 : d;
                m_cnt++;
                if (m_cnt == 1) m_irq = 1'b1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        push_valid = 1'b0; pop = 1'b0; brk_evt = 1'b0; status_clr = 1'b0;
        chk(tag, "rx_empty", 32'(rx_empty), 32'(m_cnt == 0));
        chk(tag, "rx_full", 32'(rx_full), 32'(m_cnt == lim_of(m_mode)));
        chk(tag, "can_accept", 32'(can_accept), 32'(m_cnt < lim_of(m_mode)));
        chk(tag, "rx_irq", 32'(rx_irq), 32'(m_irq));
        chk(tag, "status_byte", 32'(status_byte), 32'({4'h0, m_stat}));
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        bit fe;
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "rx_empty", 32'(rx_empty), 32'd1);
        chk("R1", "rx_full", 32'(rx_full), 32'd0);
        chk("R1", "can_accept", 32'(can_accept), 32'd1);
        chk("R1", "rx_irq", 32'(rx_irq), 32'd0);
        chk("R1", "status_byte", 32'(status_byte), 32'd0);
        chk("R1", "pop_data", 32'(pop_data), 32'd0);

        // R7 enter queue mode
        step(1, 12'h0AA, 0, 1, 0, 0, "R7");
        // R3 fill to 16, R6 irq on first push
        for (int i = 0; i < 16; i++) step(1, 12'((i << 8) | (i * 7 + 3)), 0, 1, 0, 0, (i == 0) ? "R6" : "R3");
        // R3 overflow push dropped
        step(1, 12'hFFF, 0, 1, 0, 0, "R3");
        // R2 drain in order, R8 status load
        for (int i = 0; i < 16; i++) step(0, 12'h0, 1, 1, 0, 0, (i == 15) ? "R8" : "R2");
        // R5 pops on empty
        step(0, 12'h0, 1, 1, 0, 0, "R5");
        step(0, 12'h0, 1, 1, 0, 0, "R5");
        // R8 clear, then pop wins over clear
        step(0, 12'h0, 0, 1, 0, 1, "R8");
        step(1, 12'h931, 0, 1, 0, 0, "R6");
        step(0, 12'h0, 1, 1, 0, 1, "R8");
        // R9 break ignored in queue mode
        step(0, 12'h0, 0, 1, 1, 0, "R9");
        // R7 flush with data held and irq set
        step(1, 12'h155, 0, 1, 0, 0, "R6");
        step(1, 12'h266, 1, 0, 0, 0, "R7");
        // R4 single slot
        step(1, 12'h377, 0, 0, 0, 0, "R4");
        step(1, 12'h488, 0, 0, 0, 0, "R4");
        step(0, 12'h0, 1, 0, 0, 0, "R4");
        // R9 break wins over push
        step(1, 12'h0BB, 0, 0, 1, 0, "R9");
        step(0, 12'h0, 1, 0, 0, 0, "R9");
        // R10 pop and push on full queue
        step(0, 12'h0, 0, 1, 0, 0, "R7");
        for (int i = 0; i < 16; i++) step(1, 12'(i + 12'h40), 0, 1, 0, 0, "R3");
        step(1, 12'h5CC, 1, 1, 0, 0, "R10");
        step(0, 12'h0, 0, 0, 0, 0, "R7");
        step(1, 12'h6DD, 0, 0, 0, 0, "R4");
        step(1, 12'h7EE, 1, 0, 0, 0, "R10");

        // Random mix
        fe = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 64) == 0) fe = !fe;
            step(($urandom % 2) == 0, 12'($urandom), ($urandom % 5) < 2, fe,
                 ($urandom % 20) == 0, ($urandom % 20) == 0, "R2");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule